// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Write Engine

This block is the device side of a three-wire serial EEPROM, cut down to the write command and status polling. The host raises chip select, clocks a frame in on the data input, and the block decodes it. The frame is a start bit, a two-bit write opcode, a word address and a data word. The block then runs a self-timed programming cycle into an internal byte array. A run-time organisation input picks byte words or 16-bit words. A trigger-mode input picks when programming begins: either when chip select falls after the last data bit, or on the serial clock edge that samples that bit.

While programming runs, the host can poll the block. It holds chip select low for at least a set number of system clocks and then raises it. The serial output is then driven with busy (0) or ready (1). At any other time the output enable is low, which stands for a high-impedance pin. Clocking in a start bit and then dropping chip select withdraws the status. All serial inputs are oversampled by the system clock. A side read port exposes the array contents for the rest of the chip.

Top module: `serial_eeprom_wr`

## Requirements
- R1: A frame is decoded from the first 1 on `sdi` that is sampled on a rising `sclk` while `cs` is high; any 0 bits before it are ignored. The start bit is followed by opcode bits 0 then 1, then the address MSB first, then the data MSB first.
- R2: With `org16` low, the address has ABITS bits and the data has 8 bits. The byte is stored at that byte address.
- R3: With `org16` high, the address has ABITS-1 bits and the data has 16 bits. The upper byte is stored at byte address 2·addr and the lower byte at 2·addr+1.
- R4: With `trig_clk` low, programming starts on the `cs` falling edge that follows the last data bit. If `cs` falls before all data bits have arrived, the frame is dropped.
- R5: With `trig_clk` high, programming starts on the `sclk` rising edge that samples the last data bit, while `cs` is still high.
- R6: Programming keeps the block busy for exactly WR_CYCLES system clocks. Counting from the clock that starts it, the array shows the new data from the clock after the last busy one.
- R7: Any frame that arrives while the block is busy is ignored and changes no location.
- R8: After `cs` has been sampled low on at least CSL_MIN clocks, raising it enables `sdo_oe`. `sdo` is then 0 while busy and 1 when ready. After a shorter low time, a status that was off stays off.
- R9: A 1 bit clocked in while status is shown turns `sdo_oe` off at once. The next `cs` fall clears the status, and a short low time does not bring it back.
- R10: A frame with an opcode other than 01, or a frame sent while `wen` is low, starts no busy period and changes no location.
- R11: After reset, `sdo_oe` is low and `sdo` reads ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in |
| org16 | input | 1 | 0: byte words, 1: 16-bit words |
| trig_clk | input | 1 | 0: start programming on cs fall, 1: on the last data clock |
| wen | input | 1 | Write-enable latch state; low blocks programming |
| sdo | output | 1 | Ready (1) / busy (0) status |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| peek_addr | input | ABITS | Byte address of the array read port |
| peek_data | output | 8 | Byte stored at peek_addr |

## Verification
The bench builds the block with the default ABITS of 9, so both the 512-byte and the 256-word address ranges are covered. It shortens CSL_MIN to 4, so the status-arming boundary can be probed at exactly 3 and 4 low clocks. It sets WR_CYCLES to 200. That is long enough for a whole second frame to fit inside one busy period, and short enough for the bench to follow every busy-to-ready transition clock by clock.

// File: rtl/serial_eeprom_wr.sv
module serial_eeprom_wr #(
  parameter int ABITS     = 9,
  parameter int WR_CYCLES = 1000,
  parameter int CSL_MIN   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             org16,
  input  logic             trig_clk,
  input  logic             wen,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic [ABITS-1:0] peek_addr,
  output logic [7:0]       peek_data
);
  localparam int DEPTH = 1 << ABITS;
  localparam int CW    = $clog2(ABITS + 17);
  localparam int BW    = $clog2(WR_CYCLES + 1);
  localparam int LW    = $clog2(CSL_MIN + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DATA, S_ARMED, S_DROP} st_t;

  st_t              st;
  logic             cs_q, sclk_q, op_hi, stat_en, seen_one, w16;
  logic [CW-1:0]    cnt;
  logic [ABITS-1:0] sh_a, wa;
  logic [15:0]      sh_d, wd;
  logic [BW-1:0]    busy_cnt;
  logic [LW-1:0]    low_cnt;
  logic [7:0]       mem [DEPTH];
  logic             busy;

  wire rise    = sclk & ~sclk_q & cs;
  wire cs_fall = ~cs & cs_q;
  wire cs_rise = cs & ~cs_q;
  wire [CW-1:0] alast = org16 ? CW'(ABITS - 2) : CW'(ABITS - 1);
  wire [CW-1:0] dlast = org16 ? CW'(15) : CW'(7);
  wire last_bit = (st == S_DATA) && rise && (cnt == dlast);
  wire start_b  = last_bit && trig_clk && wen && !busy;
  wire start_a  = cs_fall && (st == S_ARMED) && !trig_clk && wen && !busy;

  assign busy      = (busy_cnt != '0);
  assign sdo       = ~busy;
  assign sdo_oe    = cs & stat_en & ~seen_one;
  assign peek_data = mem[peek_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0; sclk_q <= 1'b0; st <= S_IDLE; cnt <= '0; op_hi <= 1'b0;
      sh_a <= '0; sh_d <= '0;
    end else begin
      cs_q   <= cs;
      sclk_q <= sclk;
      if (!cs) st <= S_IDLE;
      else if (busy) st <= S_DROP;
      else if (rise) begin
        case (st)
          S_IDLE: if (sdi) begin st <= S_OPC; cnt <= '0; end
          S_OPC: begin
            cnt   <= cnt + 1'b1;
            op_hi <= sdi;
            if (cnt == CW'(1)) begin
              st   <= (!op_hi && sdi) ? S_ADDR : S_DROP;
              cnt  <= '0;
              sh_a <= '0;
            end
          end
          S_ADDR: begin
            sh_a <= {sh_a[ABITS-2:0], sdi};
            cnt  <= cnt + 1'b1;
            if (cnt == alast) begin st <= S_DATA; cnt <= '0; end
          end
          S_DATA: begin
            sh_d <= {sh_d[14:0], sdi};
            cnt  <= cnt + 1'b1;
            if (cnt == dlast) st <= trig_clk ? S_DROP : S_ARMED;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0; wa <= '0; wd <= '0; w16 <= 1'b0;
    end else if (start_a || start_b) begin
      busy_cnt <= BW'(WR_CYCLES);
      wa       <= sh_a;
      wd       <= start_b ? {sh_d[14:0], sdi} : sh_d;
      w16      <= org16;
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_cnt == BW'(1)) begin
      if (w16) begin
        mem[{wa[ABITS-2:0], 1'b0}] <= wd[15:8];
        mem[{wa[ABITS-2:0], 1'b1}] <= wd[7:0];
      end else begin
        mem[wa] <= wd[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0; stat_en <= 1'b0; seen_one <= 1'b0;
    end else begin
      if (cs) low_cnt <= '0;
      else if (low_cnt < LW'(CSL_MIN)) low_cnt <= low_cnt + 1'b1;
      if (cs_rise && low_cnt >= LW'(CSL_MIN)) stat_en <= 1'b1;
      else if (cs_fall && seen_one) stat_en <= 1'b0;
      if (cs_fall) seen_one <= 1'b0;
      else if (rise && sdi) seen_one <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_eeprom_wr_chk.sv
module serial_eeprom_wr_chk #(
  parameter int WR_CYCLES = 1000,
  parameter int BW        = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          wen,
  input logic          trig_clk,
  input logic          busy,
  input logic          sdo_oe,
  input logic [BW-1:0] busy_cnt
);
  int span;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) span <= 0;
    else span <= busy ? span + 1 : 0;

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> span == WR_CYCLES); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> 32'(busy_cnt) == 32'($past(busy_cnt)) - 1); // R7
  AST_TRIG_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) && !trig_clk |-> !$past(cs)); // R4
  AST_TRIG_LAST_CLK: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) && trig_clk |-> $past(cs)); // R5
  AST_WEN_GATE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wen)); // R10
  AST_STATUS_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sdo_oe) |-> $rose(cs) || ($past(cs) && !$past(cs, 2))); // R8
endmodule

bind serial_eeprom_wr serial_eeprom_wr_chk #(.WR_CYCLES(WR_CYCLES), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wen(wen), .trig_clk(trig_clk),
  .busy(busy), .sdo_oe(sdo_oe), .busy_cnt(busy_cnt)
);

// File: tb/test_serial_eeprom_wr.sv
module test_serial_eeprom_wr;
  localparam int ABITS = 9;
  localparam int W     = 200;
  localparam int CSL   = 4;

  logic clk = 0, rst_n = 0, cs = 0, sclk = 0, sdi = 0, org16 = 0, trig_clk = 0, wen = 1;
  logic sdo, sdo_oe;
  logic [ABITS-1:0] peek_addr = '0;
  logic [7:0] peek_data;
  int cyc = 0, nchk = 0, nfail = 0, t_last = 0;
  logic [7:0] model [1 << ABITS];
  bit known [1 << ABITS];

  serial_eeprom_wr #(.ABITS(ABITS), .WR_CYCLES(W), .CSL_MIN(CSL)) i_serial_eeprom_wr (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .org16(org16),
    .trig_clk(trig_clk), .wen(wen), .sdo(sdo), .sdo_oe(sdo_oe),
    .peek_addr(peek_addr), .peek_data(peek_data));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b; tick(2); sclk = 1; t_last = cyc; tick(2); sclk = 0;
  endtask

  task automatic frame(input bit o16, input int a, input int d, input int lead,
                       input logic [1:0] op, input int nd);
    int alen = o16 ? ABITS - 1 : ABITS;
    int dlen = o16 ? 16 : 8;
    org16 = o16; cs = 0; tick(CSL + 1); cs = 1; tick(1);
    repeat (lead) send_bit(0);
    send_bit(1); send_bit(op[1]); send_bit(op[0]);
    for (int i = alen - 1; i >= 0; i--) send_bit(a[i]);
    for (int i = dlen - 1; i >= dlen - nd; i--) send_bit(d[i]);
    sdi = 0;
  endtask

  function automatic void note_write(bit o16, int a, int d);
    if (o16) begin
      model[{a[ABITS-2:0], 1'b0}] = d[15:8]; known[{a[ABITS-2:0], 1'b0}] = 1;
      model[{a[ABITS-2:0], 1'b1}] = d[7:0];  known[{a[ABITS-2:0], 1'b1}] = 1;
    end else begin
      model[a[ABITS-1:0]] = d[7:0]; known[a[ABITS-1:0]] = 1;
    end
  endfunction

  function automatic logic exp_sdo(int c, int k);
    return (k >= c + 1 && k <= c + W) ? 1'b0 : 1'b1;
  endfunction

  task automatic check_byte(input int a, input string tag);
    peek_addr = a[ABITS-1:0]; #1;
    chk(tag, {24'd0, peek_data}, {24'd0, model[a[ABITS-1:0]]});
  endtask

  task automatic write_full(input bit o16, input bit mb, input int a, input int d, input int lead);
    trig_clk = mb;
    frame(o16, a, d, lead, 2'b01, o16 ? 16 : 8);
    tick(1); cs = 0;
    tick(W + 5);
    note_write(o16, a, d);
  endtask

  task automatic poll_ready(input string tag);
    cs = 0; tick(CSL + 1); cs = 1; tick(1);
    chk({tag, " oe"}, {31'd0, sdo_oe}, 1);
    chk({tag, " ready"}, {31'd0, sdo}, 1);
    cs = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int c;
    void'($urandom(32'h5eed));
    tick(3); rst_n = 1; tick(2);
    chk("R11 reset oe", {31'd0, sdo_oe}, 0);
    chk("R11 reset ready", {31'd0, sdo}, 1);

    // R2 R5: byte write in clock-trigger mode
    write_full(0, 1, 9'h0A5, 8'h11, 0);
    check_byte(9'h0A5, "R2 R5 byte write");

    // R1 R4 R6: leading zeros, cs-fall trigger, exact busy window
    peek_addr = 9'h0A5;
    trig_clk = 0;
    frame(0, 9'h0A5, 8'h3C, 2, 2'b01, 8);
    tick(1); cs = 0; c = cyc;
    tick(CSL + 1); cs = 1;
    while (cyc < c + W + 3) begin
      tick(1);
      if (sdo_oe) chk("R6 busy status", {31'd0, sdo}, {31'd0, exp_sdo(c, cyc)});
      if (cyc == c + W) chk("R6 old data while busy", {24'd0, peek_data}, 32'h11);
      if (cyc == c + W + 1) chk("R1 R4 R6 new data", {24'd0, peek_data}, 32'h3C);
    end
    chk("R8 status still shown", {31'd0, sdo_oe}, 1);
    cs = 0;
    note_write(0, 9'h0A5, 8'h3C);

    // R3 R5: word write
    write_full(1, 1, 8'h41, 16'hBEEF, 1);
    check_byte(9'h082, "R3 upper byte");
    check_byte(9'h083, "R3 lower byte");

    // R4: abort before last data bit
    trig_clk = 0;
    frame(0, 9'h0A5, 8'hFF, 0, 2'b01, 7);
    tick(1); cs = 0; tick(W + 5);
    check_byte(9'h0A5, "R4 aborted frame");
    poll_ready("R4 no busy after abort");

    // R10: wrong opcode
    frame(0, 9'h0A5, 8'h00, 0, 2'b11, 8);
    tick(1); cs = 0; tick(W + 5);
    check_byte(9'h0A5, "R10 bad opcode");

    // R10: write enable low
    wen = 0;
    frame(0, 9'h0A5, 8'h00, 0, 2'b01, 8);
    tick(1); cs = 0;
    poll_ready("R10 wen low no busy");
    tick(W + 5);
    check_byte(9'h0A5, "R10 wen low");
    wen = 1;

    // R7: frame during busy is ignored
    trig_clk = 1;
    frame(0, 9'h0A5, 8'h5A, 0, 2'b01, 8);
    tick(1); cs = 0; tick(2);
    trig_clk = 1;
    frame(0, 9'h082, 8'h00, 0, 2'b01, 8);
    tick(1); cs = 0; tick(W + 5);
    note_write(0, 9'h0A5, 8'h5A);
    check_byte(9'h0A5, "R7 first write lands");
    check_byte(9'h082, "R7 busy frame ignored");

    // R8 R9: arming boundary and clearing
    cs = 1; tick(1); send_bit(1); cs = 0; tick(CSL - 1); cs = 1; tick(1);
    chk("R8 short low no status", {31'd0, sdo_oe}, 0);
    cs = 0; tick(CSL); cs = 1; tick(1);
    chk("R8 min low arms status", {31'd0, sdo_oe}, 1);
    chk("R8 ready level", {31'd0, sdo}, 1);
    cs = 0; tick(1); cs = 1; tick(1);
    chk("R9 status kept without start", {31'd0, sdo_oe}, 1);
    send_bit(1);
    chk("R9 start bit hides status", {31'd0, sdo_oe}, 0);
    cs = 0; tick(1); cs = 1; tick(1);
    chk("R9 status cleared", {31'd0, sdo_oe}, 0);
    cs = 0;

    // R1 R2 R3 R4 R5: random writes
    for (int n = 0; n < 30; n++) begin
      bit o16 = 1'($urandom);
      bit mb  = 1'($urandom);
      int a   = int'($urandom % (o16 ? (1 << (ABITS - 1)) : (1 << ABITS)));
      int d   = int'($urandom & 32'hFFFF);
      write_full(o16, mb, a, d, int'($urandom % 3));
      if (o16) begin
        check_byte(2 * a, "R3 random upper");
        check_byte(2 * a + 1, "R3 random lower");
      end else begin
        check_byte(a, "R2 random byte");
      end
      if (n % 5 == 0) poll_ready("R8 random poll");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule